// File: doc/BRIEF.md
# Gated Pulse Counter with Decimal Serial Report

The block counts rising edges on an asynchronous pulse input over a repeating gate window measured in system clock cycles. At the end of each window the running count and a window sequence number are copied into holding registers, the running count starts again from zero, and the held pair is turned into a line of decimal ASCII text. The line is sent on a single transmit pin as 8N1 asynchronous serial characters, ready for an external RS-232 level shifter.

The sequence number is the record's timestamp. It starts at zero after reset and advances by one per window. Because the result is held before it is sent, counting never stops. Pulses that arrive while a line is leaving are credited to the window in which they arrive. The gate length comes out of reset at a parameter value that corresponds to one minute at 100 MHz. A host may replace it at any time with a one-cycle load strobe.

Top module: `pulse_report_top`

## Requirements
- R1: While reset is asserted and after its release, `txd` is high and `overrun` is low. No start bit appears before the first window has ended.
- R2: Each low-to-high transition of `pulseIn` adds exactly one to the current window's count, whatever the length of the high level. Pulses may be as short as one clock cycle high followed by two cycles low.
- R3: The count is cleared at every window boundary. Pulses arriving while the previous line is being sent go into the new window's count.
- R4: The sequence number of the first window after reset is 0. Each later window's number is one greater than the previous one's.
- R5: Every report is 23 characters long. Characters 0 to 9 are the sequence number as ten decimal ASCII digits ('0' = 0x30) with leading zeros, most significant digit first. Character 10 is ',' (0x2C). Characters 11 to 20 are the count in the same ten-digit form. Characters 21 and 22 are CR (0x0D) and LF (0x0A).
- R6: Each character is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts `CLK_DIV` clock cycles, and the line idles high.
- R7: After reset a window lasts `GATE_DEFAULT` clock cycles. The start bits of the first characters of consecutive reports are therefore exactly one window length apart.
- R8: A one-cycle `gateLoad` with a nonzero `gateValue` sets the window length to `gateValue` cycles. This applies from the window in progress. A load with `gateValue` equal to 0 is ignored.
- R9: If a window ends while a report is still waiting or being sent, `overrun` goes high and stays high until reset. The newest result replaces the waiting one, so the reported sequence numbers skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous pulse input to be counted |
| gateLoad | input | 1 | One-cycle strobe that loads a new window length |
| gateValue | input | GATE_W | New window length in clock cycles (0 is ignored) |
| txd | output | 1 | Serial transmit line, idle high |
| overrun | output | 1 | Sticky flag: a result was replaced before it was sent |

## Verification
The hardest condition to reach from the ports is the overrun, where a window closes while the previous report is still queued or on the wire. With sensible window lengths this never happens. The bench first runs a sweep of windows with known pulse bursts and a changed window length. Only then does it load a window far shorter than the 23-character line time, so that many windows close during one transmission. It then checks that the sticky flag rises and that the sequence numbers in the following lines jump by more than one.

// File: rtl/pulse_report_pkg.sv
package pulse_report_pkg;

  localparam int VAL_W    = 32;
  localparam int DIGITS   = 10;
  localparam int BCD_W    = 4 * DIGITS;
  localparam int LINE_LEN = 2 * DIGITS + 3;
  localparam int IDX_W    = $clog2(LINE_LEN);
  localparam int STEP_W   = $clog2(VAL_W + 1);

  typedef struct packed {
    logic             takeSnap;
    logic             dabbleStep;
    logic             sendChar;
    logic [IDX_W-1:0] charIdx;
  } ctlStrobe_t;

  function automatic logic [BCD_W-1:0] addThree(input logic [BCD_W-1:0] bcdIn);
    logic [BCD_W-1:0] res;
    res = bcdIn;
    for (int d = 0; d < DIGITS; d++) begin
      if (res[4*d +: 4] >= 4'd5) res[4*d +: 4] = res[4*d +: 4] + 4'd3;
    end
    return res;
  endfunction

endpackage

// File: rtl/pulse_report_dp.sv
module pulse_report_dp
  import pulse_report_pkg::*;
#(
  parameter int              GATE_W       = 40,
  parameter longint unsigned GATE_DEFAULT = 64'd6000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              gateLoad,
  input  logic [GATE_W-1:0] gateValue,
  input  ctlStrobe_t        strobe,
  output logic              gateEnd,
  output logic [7:0]        txChar
);

  logic [2:0]        syncPipe;
  logic              pulseRise;
  logic [GATE_W-1:0] gateLen;
  logic [GATE_W-1:0] gateCnt;
  logic [VAL_W-1:0]  pulseCount, seqNum, holdCount, holdSeq, workCount, workSeq;
  logic [BCD_W-1:0]  bcdCount, bcdSeq, adjCount, adjSeq;
  logic [3:0]        seqDigit, cntDigit;

  assign pulseRise = syncPipe[1] & ~syncPipe[2];
  assign gateEnd   = (gateCnt >= gateLen - GATE_W'(1));
  assign adjSeq    = addThree(bcdSeq);
  assign adjCount  = addThree(bcdCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe <= '0;
      gateLen  <= GATE_W'(GATE_DEFAULT);
      gateCnt  <= '0;
    end else begin
      syncPipe <= {syncPipe[1:0], pulseIn};
      if (gateLoad && (gateValue != '0)) gateLen <= gateValue;
      gateCnt <= gateEnd ? '0 : gateCnt + GATE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCount <= '0;
      seqNum     <= '0;
      holdCount  <= '0;
      holdSeq    <= '0;
    end else if (gateEnd) begin
      holdCount  <= pulseCount + VAL_W'(pulseRise);
      holdSeq    <= seqNum;
      seqNum     <= seqNum + VAL_W'(1);
      pulseCount <= '0;
    end else if (pulseRise) begin
      pulseCount <= pulseCount + VAL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workCount <= '0;
      workSeq   <= '0;
      bcdCount  <= '0;
      bcdSeq    <= '0;
    end else if (strobe.takeSnap) begin
      workCount <= holdCount;
      workSeq   <= holdSeq;
      bcdCount  <= '0;
      bcdSeq    <= '0;
    end else if (strobe.dabbleStep) begin
      bcdSeq    <= {adjSeq[BCD_W-2:0], workSeq[VAL_W-1]};
      bcdCount  <= {adjCount[BCD_W-2:0], workCount[VAL_W-1]};
      workSeq   <= {workSeq[VAL_W-2:0], 1'b0};
      workCount <= {workCount[VAL_W-2:0], 1'b0};
    end
  end

  always_comb begin
    seqDigit = '0;
    cntDigit = '0;
    for (int d = 0; d < DIGITS; d++) begin
      if (IDX_W'(DIGITS - 1 - d) == strobe.charIdx) seqDigit = bcdSeq[4*d +: 4];
      if (IDX_W'(2 * DIGITS - d) == strobe.charIdx) cntDigit = bcdCount[4*d +: 4];
    end
    if (strobe.charIdx < IDX_W'(DIGITS))            txChar = {4'h3, seqDigit};
    else if (strobe.charIdx == IDX_W'(DIGITS))      txChar = 8'h2C;
    else if (strobe.charIdx <= IDX_W'(2 * DIGITS))  txChar = {4'h3, cntDigit};
    else if (strobe.charIdx == IDX_W'(2*DIGITS+1))  txChar = 8'h0D;
    else                                            txChar = 8'h0A;
  end

  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    gateEnd |=> (pulseCount == '0));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    gateEnd |=> (seqNum == $past(seqNum) + VAL_W'(1)));

  assert_gate_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    gateLen != '0);

endmodule

// File: rtl/pulse_report_ctrl.sv
module pulse_report_ctrl
  import pulse_report_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateEnd,
  input  logic       txReady,
  output ctlStrobe_t strobe,
  output logic       overrun
);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_SEND, ST_WAIT} ctlState_t;

  ctlState_t         state;
  logic              pending;
  logic [STEP_W-1:0] stepCnt;
  logic [IDX_W-1:0]  charIdx;

  always_comb begin
    strobe.takeSnap   = (state == ST_IDLE) && pending;
    strobe.dabbleStep = (state == ST_CONV);
    strobe.sendChar   = (state == ST_SEND) && txReady;
    strobe.charIdx    = charIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (gateEnd) pending <= 1'b1;
      else if (strobe.takeSnap) pending <= 1'b0;
      if (gateEnd && ((pending && !strobe.takeSnap) || (state != ST_IDLE)))
        overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      charIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (pending) begin
          state   <= ST_CONV;
          stepCnt <= '0;
        end
        ST_CONV: begin
          stepCnt <= stepCnt + STEP_W'(1);
          if (stepCnt == STEP_W'(VAL_W - 1)) begin
            state   <= ST_SEND;
            charIdx <= '0;
          end
        end
        ST_SEND: if (txReady) state <= ST_WAIT;
        ST_WAIT: if (txReady) begin
          if (charIdx == IDX_W'(LINE_LEN - 1)) state <= ST_IDLE;
          else begin
            charIdx <= charIdx + IDX_W'(1);
            state   <= ST_SEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  assert_char_idx_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    charIdx < IDX_W'(LINE_LEN));

endmodule

// File: rtl/pulse_report_uart.sv
module pulse_report_uart #(
  parameter int CLK_DIV = 868
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txReady,
  output logic       txd
);

  localparam int FRAME_W = 10;
  localparam int DIV_W   = $clog2(CLK_DIV + 1);
  localparam int BIT_W   = $clog2(FRAME_W + 1);

  logic               busy;
  logic [FRAME_W-1:0] frame;
  logic [DIV_W-1:0]   baudCnt;
  logic [BIT_W-1:0]   bitsLeft;

  assign txReady = !busy;
  assign txd     = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      frame    <= '1;
      baudCnt  <= '0;
      bitsLeft <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      frame    <= {1'b1, data, 1'b0};
      baudCnt  <= DIV_W'(CLK_DIV - 1);
      bitsLeft <= BIT_W'(FRAME_W);
    end else if (busy) begin
      if (baudCnt == '0) begin
        frame    <= {1'b1, frame[FRAME_W-1:1]};
        baudCnt  <= DIV_W'(CLK_DIV - 1);
        bitsLeft <= bitsLeft - BIT_W'(1);
        if (bitsLeft == BIT_W'(1)) busy <= 1'b0;
      end else begin
        baudCnt <= baudCnt - DIV_W'(1);
      end
    end
  end

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> (txd || busy));

endmodule

// File: rtl/pulse_report_top.sv
module pulse_report_top
  import pulse_report_pkg::*;
#(
  parameter int              CLK_DIV      = 868,
  parameter int              GATE_W       = 40,
  parameter longint unsigned GATE_DEFAULT = 64'd6000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              gateLoad,
  input  logic [GATE_W-1:0] gateValue,
  output logic              txd,
  output logic              overrun
);

  ctlStrobe_t strobe;
  logic       gateEnd;
  logic       txReady;
  logic [7:0] txChar;

  pulse_report_dp #(.GATE_W(GATE_W), .GATE_DEFAULT(GATE_DEFAULT)) uDp (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .gateLoad(gateLoad),
    .gateValue(gateValue), .strobe(strobe), .gateEnd(gateEnd), .txChar(txChar)
  );

  pulse_report_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .gateEnd(gateEnd), .txReady(txReady),
    .strobe(strobe), .overrun(overrun)
  );

  pulse_report_uart #(.CLK_DIV(CLK_DIV)) uUart (
    .clk(clk), .rstN(rstN), .start(strobe.sendChar), .data(txChar),
    .txReady(txReady), .txd(txd)
  );

endmodule

// File: tb/tb_pulse_report_top.sv
module tb_pulse_report_top;

  localparam int CLK_DIV = 4;
  localparam int GATE_W  = 40;
  localparam int G1      = 1200;
  localparam int G2      = 1400;
  localparam int NSWEEP  = 18;
  localparam int LINE_N  = 23;

  logic              clk = 1'b0;
  logic              rstN;
  logic              pulseIn;
  logic              gateLoad;
  logic [GATE_W-1:0] gateValue;
  logic              txd;
  logic              overrun;

  int     nChecks = 0;
  int     nFails  = 0;
  longint cyc = 0;

  byte    lineBuf [LINE_N];
  int     pos = 0;
  longint lineSeq [64];
  longint lineCnt [64];
  longint lineStart [64];
  int     numLines = 0;
  longint curStart = 0;

  always #5 clk = ~clk;

  pulse_report_top #(.CLK_DIV(CLK_DIV), .GATE_W(GATE_W), .GATE_DEFAULT(64'(G1))) dut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .gateLoad(gateLoad),
    .gateValue(gateValue), .txd(txd), .overrun(overrun)
  );

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int burstLen(input int k);
    if (k < 16) return k;
    return (k == 16) ? 100 : 200;
  endfunction

  function automatic int highWidth(input int k);
    if (k < 16) return 1 + (k % 4) * 15;
    return 1;
  endfunction

  task automatic parseLine();
    longint s = 0;
    longint c = 0;
    for (int i = 0; i < 10; i++) begin
      check(lineBuf[i] >= 8'h30 && lineBuf[i] <= 8'h39, "R5 seq digit", lineBuf[i], 8'h30);
      s = s * 10 + (lineBuf[i] - 8'h30);
    end
    check(lineBuf[10] == 8'h2C, "R5 comma", lineBuf[10], 8'h2C);
    for (int i = 11; i < 21; i++) begin
      check(lineBuf[i] >= 8'h30 && lineBuf[i] <= 8'h39, "R5 count digit", lineBuf[i], 8'h30);
      c = c * 10 + (lineBuf[i] - 8'h30);
    end
    check(lineBuf[21] == 8'h0D, "R5 CR", lineBuf[21], 8'h0D);
    check(lineBuf[22] == 8'h0A, "R5 LF", lineBuf[22], 8'h0A);
    if (numLines < 64) begin
      lineSeq[numLines]   = s;
      lineCnt[numLines]   = c;
      lineStart[numLines] = curStart;
    end
    numLines++;
  endtask

  // serial receiver (R6)
  initial begin
    byte    ch;
    longint st;
    forever begin
      @(negedge clk);
      if (rstN && txd == 1'b0) begin
        st = cyc;
        repeat (CLK_DIV / 2) @(negedge clk);
        check(txd == 1'b0, "R6 start bit", txd, 0);
        for (int b = 0; b < 8; b++) begin
          repeat (CLK_DIV) @(negedge clk);
          ch[b] = txd;
        end
        repeat (CLK_DIV) @(negedge clk);
        check(txd == 1'b1, "R6 stop bit", txd, 1);
        if (pos == 0) curStart = st;
        lineBuf[pos] = ch;
        pos++;
        if (pos == LINE_N) begin
          parseLine();
          pos = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", numLines, 26);
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; pulseIn = 1'b0; gateLoad = 1'b0; gateValue = '0;
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R1 txd idle in reset", txd, 1);
    check(overrun == 1'b0, "R1 overrun clear in reset", overrun, 0);
    rstN = 1'b1;

    // sweep windows with known bursts, long highs counting once (R2, R3)
    for (int k = 0; k < NSWEEP; k++) begin
      while (cyc < longint'(k) * G1 + 300) @(negedge clk);
      for (int p = 0; p < burstLen(k); p++) begin
        pulseIn = 1'b1;
        repeat (highWidth(k)) @(negedge clk);
        pulseIn = 1'b0;
        repeat (2) @(negedge clk);
      end
    end

    // R8: new length applies to the window in progress
    while (cyc < longint'(NSWEEP) * G1 + 50) @(negedge clk);
    gateValue = GATE_W'(G2); gateLoad = 1'b1;
    @(negedge clk); gateLoad = 1'b0;
    // R8: zero load ignored
    while (cyc < longint'(NSWEEP) * G1 + 2 * G2 + 100) @(negedge clk);
    gateValue = '0; gateLoad = 1'b1;
    @(negedge clk); gateLoad = 1'b0;

    while (numLines < 23) @(negedge clk);
    check(lineStart[0] >= G1, "R1 no frame before first window", lineStart[0], G1);
    for (int k = 0; k < 23; k++) begin
      check(lineSeq[k] == k, "R4 sequence number", lineSeq[k], k);
      check(lineCnt[k] == ((k < NSWEEP) ? burstLen(k) : 0), "R2 R3 window count",
            lineCnt[k], (k < NSWEEP) ? burstLen(k) : 0);
    end
    for (int k = 1; k < NSWEEP; k++)
      check(lineStart[k] - lineStart[k-1] == G1, "R7 default window spacing",
            lineStart[k] - lineStart[k-1], G1);
    for (int k = NSWEEP; k < 23; k++)
      check(lineStart[k] - lineStart[k-1] == G2, "R8 loaded window spacing",
            lineStart[k] - lineStart[k-1], G2);
    check(overrun == 1'b0, "R9 no overrun with long windows", overrun, 0);

    // R9: window much shorter than a line
    gateValue = GATE_W'(100); gateLoad = 1'b1;
    @(negedge clk); gateLoad = 1'b0;
    while (numLines < 26) @(negedge clk);
    check(overrun == 1'b1, "R9 overrun raised", overrun, 1);
    check(lineSeq[25] > lineSeq[24] + 1, "R9 newer result kept", lineSeq[25], lineSeq[24] + 2);
    check(lineCnt[25] == 0, "R3 idle count", lineCnt[25], 0);
    repeat (50) @(negedge clk);
    check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    summary();
    $finish;
  end

endmodule